// File: doc/BRIEF.md
# Externally Clocked Synchronous Serial Transmitter

This block sends words over a single data line. The shift clock comes from an external master, and the block never makes a clock of its own. The host writes a word into a write-only holding register. If the shift register is idle, the word goes straight into the shift register and waits there until the master clocks it out. If a frame is already in flight, the word waits in the holding register and the holding-empty flag stays low. The queued word moves into the shift register only when the last bit of the current frame has been shifted out, and at that moment the holding-empty flag rises. With the interrupt enable set, a high holding-empty flag raises the interrupt request, which can serve as a wake-up source.

A frame carries 8 bits, or 9 bits when nine-bit mode is selected at the time of the write. The ninth bit comes from a separate input bit. Data leaves least significant bit first. The output changes after each falling edge of the external clock, so the master samples it on the rising edge. The external clock passes through a two-flop synchronizer, and its edges are detected in the system clock domain. The system clock must run at least four times faster than the external clock.

Top module: `sync_slave_tx`

## Requirements
- R1: The shift register advances only on a falling edge of `ext_sclk`, detected after synchronization. With no such edge, `sdo` and `shift_empty` hold their values however long the wait.
- R2: A write into an empty holding register while the shift register is idle loads the shift register directly. Within 2 system clocks `hold_empty` is still 1, `shift_empty` is 0 and `sdo` shows bit 0 of the word.
- R3: A write while a frame is in flight and the holding register is empty is stored in the holding register. `hold_empty` is 0 from the next cycle until that frame ends.
- R4: On the falling edge that ends the last bit of a frame, a pending word moves into the shift register. `hold_empty` then returns to 1, `shift_empty` stays 0 and `sdo` shows bit 0 of the new word.
- R5: `irq` equals `irq_en AND hold_empty` as registered one system clock earlier.
- R6: The block is active only when `port_en`=1, `sync_mode`=1, `clk_src_int`=0, `rx_cont_en`=0, `rx_single_en`=0 and `tx_en`=1. While it is inactive, writes are ignored and both registers read empty with `sdo`=1.
- R7: A frame is 8 bits, from `wr_data[0]` first to `wr_data[7]`, when `nine_bit`=0 at the write. When `nine_bit`=1 it is 9 bits, with `wr_bit9` sent last. The frame length is chosen for each word.
- R8: After reset, `hold_empty`=1, `shift_empty`=1, `sdo`=1 and `irq`=0.
- R9: When the shift register is empty and no word is pending, `sdo` is 1 and `shift_empty` is 1.
- R10: A write while the holding register is full is dropped, and the pending word is kept unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_sclk | input | 1 | Shift clock from the external master (asynchronous) |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select |
| clk_src_int | input | 1 | Clock source select, must be 0 for slave operation |
| rx_cont_en | input | 1 | Continuous receive enable, must be 0 |
| rx_single_en | input | 1 | Single receive enable, must be 0 |
| tx_en | input | 1 | Transmit enable |
| nine_bit | input | 1 | Nine-bit frame select, captured at each write |
| irq_en | input | 1 | Transmit interrupt enable |
| wr_en | input | 1 | One-cycle write strobe into the holding register |
| wr_data | input | 8 | Data word to send |
| wr_bit9 | input | 1 | Ninth bit, used when nine_bit is 1 |
| sdo | output | 1 | Serial data output |
| hold_empty | output | 1 | Holding register empty flag |
| shift_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Gated transmit interrupt request |

## Verification
A wrong bit counter or frame length shows up as a frame that is shifted, truncated or one bit longer, seen on `sdo` at the master's next sampling edge. A wrong handoff between the holding and shift registers shows up on `hold_empty` within two system clocks of the write or of the frame-ending edge. In that case a queued word is lost, sent twice or overwritten, and the next frame's bits reveal it. A faulty enable decode or interrupt gate is visible on `hold_empty`, `shift_empty` and `irq` one or two cycles after the configuration or the write changes.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  typedef struct packed {
    logic              nine;
    logic [DATA_W:0]   bits;
  } word_t;
endpackage

// File: rtl/sst_edge_sync.sv
module sst_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= 1'b0;
    else     pipe[0] <= async_in;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= 1'b0;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/sst_hold.sv
module sst_hold import sst_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  active,
  input  logic  capture,
  input  logic  take,
  input  word_t cap_word,
  output logic  full,
  output word_t word
);
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      full <= 1'b0;
      word <= '0;
    end else if (capture) begin
      full <= 1'b1;
      word <= cap_word;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R10
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !take && active) |=> (full && $stable(word)));
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter import sst_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  active,
  input  logic  fall,
  input  logic  load,
  input  word_t ld_word,
  output logic  empty,
  output logic  sdo,
  output logic  req_next
);
  logic [DATA_W:0]  sreg;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             at_last;

  assign at_last  = (cnt == last);
  assign req_next = empty | (fall & at_last);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      empty <= 1'b1;
      sdo   <= 1'b1;
      cnt   <= '0;
      last  <= '0;
      sreg  <= '0;
    end else if ((!empty && fall && at_last && load) || (empty && load)) begin
      sreg  <= ld_word.bits;
      sdo   <= ld_word.bits[0];
      cnt   <= '0;
      last  <= ld_word.nine ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
      empty <= 1'b0;
    end else if (!empty && fall) begin
      if (at_last) begin
        empty <= 1'b1;
        sdo   <= 1'b1;
      end else begin
        cnt  <= cnt + 1'b1;
        sreg <= {1'b0, sreg[DATA_W:1]};
        sdo  <= sreg[1];
      end
    end
  end

  // R1
  no_edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !fall && !load) |=> ($stable(sdo) && $stable(empty)));

  // R9
  idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> sdo);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx import sst_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_sclk,
  input  logic              port_en,
  input  logic              sync_mode,
  input  logic              clk_src_int,
  input  logic              rx_cont_en,
  input  logic              rx_single_en,
  input  logic              tx_en,
  input  logic              nine_bit,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_bit9,
  output logic              sdo,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              irq
);
  logic  active, fall, hold_full, sh_empty, req_next;
  logic  wr_acc, direct, capture, take, load;
  word_t in_word, hold_word, ld_word;

  assign active  = port_en & sync_mode & ~clk_src_int & ~rx_cont_en
                 & ~rx_single_en & tx_en;
  assign in_word = '{nine: nine_bit, bits: {wr_bit9 & nine_bit, wr_data}};
  assign wr_acc  = wr_en & active & ~hold_full;
  assign direct  = wr_acc & sh_empty;
  assign capture = wr_acc & ~sh_empty;
  assign take    = req_next & hold_full & active;
  assign load    = direct | take;
  assign ld_word = take ? hold_word : in_word;

  sst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(ext_sclk), .fall(fall)
  );

  sst_hold u_hold (
    .clk(clk), .rst(rst), .active(active), .capture(capture), .take(take),
    .cap_word(in_word), .full(hold_full), .word(hold_word)
  );

  sst_shifter u_shift (
    .clk(clk), .rst(rst), .active(active), .fall(fall), .load(load),
    .ld_word(ld_word), .empty(sh_empty), .sdo(sdo), .req_next(req_next)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en & ~hold_full;
  end

  assign hold_empty  = ~hold_full;
  assign shift_empty = sh_empty;

  // R4
  handoff_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (hold_empty && !shift_empty));

  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(irq_en && hold_empty)));

  // R6
  inactive_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (hold_empty && shift_empty && sdo));

  // R3
  pending_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (capture && !fall) |=> !hold_empty);
endmodule

// File: tb/tb_sync_slave_tx.sv
module tb_sync_slave_tx;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1, ext_sclk = 1'b0;
  logic port_en = 0, sync_mode = 0, clk_src_int = 0, rx_cont_en = 0;
  logic rx_single_en = 0, tx_en = 0, nine_bit = 0, irq_en = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic wr_bit9 = 0;
  logic sdo, hold_empty, shift_empty, irq;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_slave_tx dut (
    .clk(clk), .rst(rst), .ext_sclk(ext_sclk), .port_en(port_en),
    .sync_mode(sync_mode), .clk_src_int(clk_src_int), .rx_cont_en(rx_cont_en),
    .rx_single_en(rx_single_en), .tx_en(tx_en), .nine_bit(nine_bit),
    .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .wr_bit9(wr_bit9),
    .sdo(sdo), .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
  );

  function automatic logic [8:0] exp_frame(logic [7:0] d, logic b9, logic nine);
    return {b9 & nine, d};
  endfunction

  function automatic int frame_len(logic nine);
    return nine ? 9 : 8;
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg_ok();
    @(negedge clk);
    port_en = 1; sync_mode = 1; clk_src_int = 0;
    rx_cont_en = 0; rx_single_en = 0; tx_en = 1;
  endtask

  task automatic write_word(logic [7:0] d, logic b9, logic nine);
    @(negedge clk);
    wr_en = 1; wr_data = d; wr_bit9 = b9; nine_bit = nine;
    @(negedge clk);
    wr_en = 0; wr_data = $urandom; wr_bit9 = $urandom; nine_bit = $urandom;
  endtask

  task automatic clock_frame(int n, output logic [8:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      got[i] = sdo;
      ext_sclk = 1'b1;
      cycles(4);
      ext_sclk = 1'b0;
      cycles(6);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [8:0] got;
    void'($urandom(32'h5EED_1234));
    cycles(3);
    // R8 reset values
    chk("R8 hold_empty", hold_empty, 1);
    chk("R8 shift_empty", shift_empty, 1);
    chk("R8 sdo", sdo, 1);
    chk("R8 irq", irq, 0);
    @(negedge clk) rst = 0;
    cfg_ok();
    irq_en = 1;
    cycles(2);

    // R2 direct load
    write_word(8'h5A, 1'b0, 1'b0);
    cycles(1);
    chk("R2 hold_empty", hold_empty, 1);
    chk("R2 shift_empty", shift_empty, 0);
    chk("R2 sdo bit0", sdo, 0);
    // R1 no clock edges, nothing moves
    cycles(50);
    chk("R1 sdo stable", sdo, 0);
    chk("R1 shift_empty stable", shift_empty, 0);

    // R3 queued word while busy
    write_word(8'h3C, 1'b1, 1'b1);
    cycles(1);
    chk("R3 hold_empty low", hold_empty, 0);
    chk("R3 irq low", irq, 0);
    // R10 write while full dropped
    write_word(8'hFF, 1'b0, 1'b0);
    cycles(1);
    chk("R10 hold still full", hold_empty, 0);

    // R7 first frame 8 bits LSB first
    clock_frame(8, got);
    chk("R7 frame A", got, exp_frame(8'h5A, 0, 0));
    // R4 handoff
    chk("R4 hold_empty", hold_empty, 1);
    chk("R4 shift_empty", shift_empty, 0);
    chk("R4 sdo new bit0", sdo, 0);
    chk("R5 irq set", irq, 1);
    clock_frame(9, got);
    chk("R7 nine-bit frame / R10 kept word", got, exp_frame(8'h3C, 1, 1));
    // R9 idle
    chk("R9 sdo idle", sdo, 1);
    chk("R9 shift_empty idle", shift_empty, 1);

    // R5 irq gated off
    @(negedge clk) irq_en = 0;
    cycles(2);
    chk("R5 irq gated", irq, 0);

    // R6 wrong configurations ignore writes
    @(negedge clk) clk_src_int = 1;
    write_word(8'h00, 0, 0);
    cycles(1);
    chk("R6 clk_src_int shift_empty", shift_empty, 1);
    chk("R6 clk_src_int sdo", sdo, 1);
    cfg_ok();
    @(negedge clk) rx_cont_en = 1;
    write_word(8'h00, 0, 0);
    cycles(1);
    chk("R6 rx_cont shift_empty", shift_empty, 1);
    cfg_ok();
    @(negedge clk) rx_single_en = 1;
    write_word(8'h00, 0, 0);
    cycles(1);
    chk("R6 rx_single shift_empty", shift_empty, 1);
    cfg_ok();
    // R6 disable mid-frame clears both
    write_word(8'h12, 0, 0);
    write_word(8'h34, 0, 0);
    @(negedge clk) tx_en = 0;
    cycles(2);
    chk("R6 disable hold_empty", hold_empty, 1);
    chk("R6 disable shift_empty", shift_empty, 1);
    chk("R6 disable sdo", sdo, 1);
    cfg_ok();
    cycles(2);

    // random traffic
    for (int it = 0; it < 40; it++) begin
      logic [7:0] d1, d2;
      logic n1, n2, b1, b2, two, ie;
      d1 = $urandom; d2 = $urandom; n1 = $urandom; n2 = $urandom;
      b1 = $urandom; b2 = $urandom; two = $urandom; ie = $urandom;
      @(negedge clk) irq_en = ie;
      write_word(d1, b1, n1);
      if (two) write_word(d2, b2, n2);
      cycles(1);
      chk("R3 random hold_empty", hold_empty, !two);
      clock_frame(frame_len(n1), got);
      chk("R7 random frame 1", got, exp_frame(d1, b1, n1));
      chk("R5 random irq", irq, ie);
      if (two) begin
        chk("R4 random handoff", shift_empty, 0);
        clock_frame(frame_len(n2), got);
        chk("R7 random frame 2", got, exp_frame(d2, b2, n2));
      end
      chk("R9 random idle", {shift_empty, sdo}, 2'b11);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule